// File: doc/BRIEF.md
# Serial Link Activity Power Controller

This block is the digital power manager for a line transceiver that switches itself on and off according to traffic on the link. Each receiver channel supplies one digitized flag that is high while its input carries a valid signal level. From these flags and three control pins, the block decides when the charge pump and the line drivers run. It also reports whether any remote signal is present, controls tristating of the normal receiver outputs, and keeps a ring-monitor receiver enabled.

There are three operating modes. When the power-down pin is asserted, the pump and the drivers are off, regardless of the other pins. When the force pin is high, the drivers come up after a rail-recovery delay and stay up. Otherwise the block runs in automatic mode. In that mode, activity on any channel starts the pump. The drivers follow once the wake delay has elapsed. After every channel has been quiet for the sleep timeout, both the pump and the drivers are switched off. All delays are counted in clock cycles and set by parameters. Every pin input passes through a two-flop synchronizer before the block uses it.

Top module: `link_power_ctrl`

## Requirements
- R1: After reset is released with no channel active and force_on low, pump_en, drv_en and link_seen read 0, and ring_mon_en reads 1.
- R2: While pwr_down_n is low (power-down asserted), pump_en and drv_en go to 0 on the third clock edge after the pin falls. They stay 0 even when force_on is 1 or channels are active.
- R3: With pwr_down_n high and force_on high, pump_en rises on the third edge and drv_en on edge WAKE_CYC+3 after the mode is entered. drv_en then stays 1 without any activity. Once force_on returns to 0 with no activity, drv_en falls on edge SLEEP_CYC+2.
- R4: In automatic mode (pwr_down_n high, force_on low), a rising activity flag starts the wake-up from the off state. pump_en rises on the third edge after the flag rises, and drv_en rises on edge WAKE_CYC+3.
- R5: In automatic mode with drivers on, after all flags fall, drv_en and pump_en fall on edge SLEEP_CYC+2 and are still 1 after edge SLEEP_CYC+1.
- R6: Any activity during the sleep countdown restarts the countdown from zero.
- R7: Activity that drops or returns while the wake-up is in progress does not change when drv_en rises.
- R8: link_seen rises on edge ST_ON_CYC+2 after activity starts and falls on edge ST_OFF_CYC+2 after all channels go quiet. This holds in every mode, including power-down.
- R9: Activity lasting fewer than ST_ON_CYC synchronized cycles leaves link_seen at 0.
- R10: rx_hiz high (tristate requested) drives rxout_oe (1 = outputs driving) to 0 on the second edge, and rx_hiz low drives it back to 1 on the second edge. Power-down does not affect rxout_oe.
- R11: ring_mon_en stays 1 in every mode after reset is released, including power-down and tristate.
- R12: Any single channel, including the highest index, is enough to wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_active | input | N_CH | Per-channel activity flag, asynchronous |
| pwr_down_n | input | 1 | Active-low power-down, dominant over all modes |
| force_on | input | 1 | 1 = keep drivers on permanently, 0 = automatic mode |
| rx_hiz | input | 1 | 1 = tristate the normal receiver outputs |
| link_seen | output | 1 | Remote signal present, filtered |
| pump_en | output | 1 | Charge pump enable |
| drv_en | output | 1 | Line driver enable |
| rxout_oe | output | 1 | Normal receiver output enable (1 = driving) |
| ring_mon_en | output | 1 | Always-on ring-monitor receiver enable |

## Verification
The assertions check the following properties on every cycle:
- Power-down clears both enables on the next edge.
- Forced mode never drops the drivers.
- The drivers only rise while the pump is already running.
- The pump only falls after power-down or with no activity present.
- link_seen only changes in the direction the synchronized activity points.

Only the bench scenarios can show the exact wake, sleep and filter delays, the restart of the sleep countdown, the immunity of the wake timer to activity gaps, and the behaviour of the tristate and ring-monitor outputs across modes.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    PW_OFF  = 2'd0,
    PW_WAKE = 2'd1,
    PW_ON   = 2'd2
  } pw_state_t;
endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lpc_status_det.sv
module lpc_status_det #(
  parameter int ON_CYC  = 4,
  parameter int OFF_CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic any_act,
  output logic seen
);
  localparam int MAXC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYC - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYC - 1);

  logic [CW-1:0] cnt;

  // One counter filters both edges: it counts while the input disagrees with the output.
  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      cnt  <= '0;
    end else if (any_act == seen) begin
      cnt <= '0;
    end else if (cnt == (seen ? OFF_LAST : ON_LAST)) begin
      seen <= ~seen;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_seen_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(seen) |-> $past(any_act));
  p_seen_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(seen) |-> !$past(any_act));
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(MAXC));
endmodule

// File: rtl/lpc_power_fsm.sv
module lpc_power_fsm
  import lpc_pkg::*;
#(
  parameter int WAKE_CYC  = 400,
  parameter int SLEEP_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic any_act,
  input  logic shut,
  input  logic forced,
  output logic pump_en,
  output logic drv_en
);
  localparam int MAXC = (WAKE_CYC > SLEEP_CYC) ? WAKE_CYC : SLEEP_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] SLEEP_LAST = CW'(SLEEP_CYC - 1);

  pw_state_t     state;
  logic [CW-1:0] cnt;
  logic          keep;

  assign keep = forced | any_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PW_OFF;
      cnt   <= '0;
    end else if (shut) begin
      state <= PW_OFF;
      cnt   <= '0;
    end else begin
      case (state)
        PW_OFF: begin
          cnt <= '0;
          if (keep) state <= PW_WAKE;
        end
        PW_WAKE: begin
          // wake timer runs to completion regardless of activity
          if (cnt == WAKE_LAST) begin
            state <= PW_ON;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PW_ON: begin
          if (keep) begin
            cnt <= '0;
          end else if (cnt == SLEEP_LAST) begin
            state <= PW_OFF;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= PW_OFF;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign pump_en = (state != PW_OFF);
  assign drv_en  = (state == PW_ON);

  p_shut_off_r2: assert property (@(posedge clk) disable iff (rst)
    shut |=> (!pump_en && !drv_en));
  p_forced_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (forced && !shut && drv_en) |=> drv_en);
  p_wake_order_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en) |-> $past(pump_en));
  p_sleep_idle_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(pump_en) |-> ($past(shut) || !$past(keep)));
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(MAXC));
endmodule

// File: rtl/link_power_ctrl.sv
module link_power_ctrl #(
  parameter int N_CH        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ST_ON_CYC   = 4,
  parameter int ST_OFF_CYC  = 40,
  parameter int WAKE_CYC    = 400,
  parameter int SLEEP_CYC   = 200
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] rx_active,
  input  logic            pwr_down_n,
  input  logic            force_on,
  input  logic            rx_hiz,
  output logic            link_seen,
  output logic            pump_en,
  output logic            drv_en,
  output logic            rxout_oe,
  output logic            ring_mon_en
);
  localparam int CTL_W = 3;
  // control sync bit order: [2] pwr_down_n, [1] force_on, [0] rx_hiz
  localparam logic [CTL_W-1:0] CTL_RST = 3'b001;

  logic [N_CH-1:0]  act_s;
  logic [CTL_W-1:0] ctl_s;
  logic             any_act;

  lpc_sync #(.W(N_CH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_act_sync (
    .clk(clk), .rst(rst), .d(rx_active), .q(act_s)
  );

  lpc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
    .clk(clk), .rst(rst), .d({pwr_down_n, force_on, rx_hiz}), .q(ctl_s)
  );

  assign any_act = |act_s;

  lpc_status_det #(.ON_CYC(ST_ON_CYC), .OFF_CYC(ST_OFF_CYC)) u_status (
    .clk(clk), .rst(rst), .any_act(any_act), .seen(link_seen)
  );

  lpc_power_fsm #(.WAKE_CYC(WAKE_CYC), .SLEEP_CYC(SLEEP_CYC)) u_fsm (
    .clk(clk), .rst(rst), .any_act(any_act),
    .shut(~ctl_s[2]), .forced(ctl_s[1]),
    .pump_en(pump_en), .drv_en(drv_en)
  );

  assign rxout_oe = ~ctl_s[0];

  always_ff @(posedge clk) begin
    if (rst) ring_mon_en <= 1'b0;
    else     ring_mon_en <= 1'b1;
  end

  p_drv_has_pump_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_en) |-> !drv_en);
endmodule

// File: tb/link_power_ctrl_test.sv
module link_power_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH  = 2;
  localparam int ST_ON = 4;
  localparam int ST_OFF = 40;
  localparam int WAKE  = 400;
  localparam int SLEEP = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_CH-1:0] rx_active = '0;
  logic pwr_down_n = 1'b1;
  logic force_on = 1'b0;
  logic rx_hiz = 1'b0;
  logic link_seen, pump_en, drv_en, rxout_oe, ring_mon_en;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_power_ctrl #(
    .N_CH(N_CH), .SYNC_STAGES(2), .ST_ON_CYC(ST_ON), .ST_OFF_CYC(ST_OFF),
    .WAKE_CYC(WAKE), .SLEEP_CYC(SLEEP)
  ) uut (
    .clk(clk), .rst(rst), .rx_active(rx_active), .pwr_down_n(pwr_down_n),
    .force_on(force_on), .rx_hiz(rx_hiz), .link_seen(link_seen),
    .pump_en(pump_en), .drv_en(drv_en), .rxout_oe(rxout_oe),
    .ring_mon_en(ring_mon_en)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    step(5);
    rst = 1'b0;
    step(5);
    chk("R1", "pump_en", pump_en, 1'b0);
    chk("R1", "drv_en", drv_en, 1'b0);
    chk("R1", "link_seen", link_seen, 1'b0);
    chk("R1", "ring_mon_en", ring_mon_en, 1'b1);
  endtask

  task automatic t_auto_wake();
    rx_active = 2'b10;               // highest channel only (R12)
    step(2);
    chk("R4", "pump before edge 3", pump_en, 1'b0);
    step(1);
    chk("R12", "pump on from top channel", pump_en, 1'b1);
    step(WAKE - 1);
    chk("R4", "drv before edge WAKE+3", drv_en, 1'b0);
    step(1);
    chk("R4", "drv at edge WAKE+3", drv_en, 1'b1);
  endtask

  task automatic t_sleep_restart();
    rx_active = '0;
    step(SLEEP / 2);
    rx_active = 2'b01;
    step(3);
    rx_active = '0;
    step(SLEEP + 1);
    chk("R6", "drv kept by restarted countdown", drv_en, 1'b1);
    chk("R5", "drv at edge SLEEP+1", drv_en, 1'b1);
    step(1);
    chk("R5", "drv at edge SLEEP+2", drv_en, 1'b0);
    chk("R5", "pump at edge SLEEP+2", pump_en, 1'b0);
  endtask

  task automatic t_wake_no_restart();
    rx_active = 2'b01;
    step(3);
    chk("R7", "pump on", pump_en, 1'b1);
    rx_active = '0;
    step(10);
    rx_active = 2'b01;
    step(WAKE + 2 - 13);
    chk("R7", "drv before edge WAKE+3", drv_en, 1'b0);
    step(1);
    chk("R7", "drv at edge WAKE+3 despite gap", drv_en, 1'b1);
  endtask

  task automatic t_status();
    step(ST_ON + 4);
    chk("R8", "link_seen high with activity", link_seen, 1'b1);
    rx_active = '0;
    step(ST_OFF + 1);
    chk("R8", "link_seen before fall edge", link_seen, 1'b1);
    step(1);
    chk("R8", "link_seen after fall edge", link_seen, 1'b0);
    rx_active = 2'b10;
    step(ST_ON - 1);
    rx_active = '0;
    step(10);
    chk("R9", "short burst filtered", link_seen, 1'b0);
    pwr_down_n = 1'b0;
    step(5);
    rx_active = 2'b01;
    step(ST_ON + 1);
    chk("R8", "link_seen before rise in power-down", link_seen, 1'b0);
    step(1);
    chk("R8", "link_seen rises in power-down", link_seen, 1'b1);
    chk("R2", "drv off in power-down with activity", drv_en, 1'b0);
    chk("R2", "pump off in power-down with activity", pump_en, 1'b0);
  endtask

  task automatic t_shutdown();
    pwr_down_n = 1'b1;
    step(WAKE + 10);
    chk("R2", "drv on before power-down", drv_en, 1'b1);
    pwr_down_n = 1'b0;
    step(2);
    chk("R2", "drv at edge 2", drv_en, 1'b1);
    step(1);
    chk("R2", "drv at edge 3", drv_en, 1'b0);
    chk("R2", "pump at edge 3", pump_en, 1'b0);
    force_on = 1'b1;
    step(20);
    chk("R2", "drv stays off with force_on", drv_en, 1'b0);
    chk("R2", "pump stays off with force_on", pump_en, 1'b0);
    chk("R11", "ring monitor in power-down", ring_mon_en, 1'b1);
  endtask

  task automatic t_forced();
    rx_active = '0;
    step(5);
    pwr_down_n = 1'b1;
    step(2);
    chk("R3", "pump at edge 2", pump_en, 1'b0);
    step(1);
    chk("R3", "pump at edge 3", pump_en, 1'b1);
    step(WAKE - 1);
    chk("R3", "drv at edge WAKE+2", drv_en, 1'b0);
    step(1);
    chk("R3", "drv at edge WAKE+3", drv_en, 1'b1);
    step(SLEEP + 50);
    chk("R3", "drv held without activity", drv_en, 1'b1);
    force_on = 1'b0;
    step(SLEEP + 1);
    chk("R3", "drv after leaving force, edge SLEEP+1", drv_en, 1'b1);
    step(1);
    chk("R3", "drv after leaving force, edge SLEEP+2", drv_en, 1'b0);
  endtask

  task automatic t_rx_oe();
    chk("R10", "oe driving", rxout_oe, 1'b1);
    rx_hiz = 1'b1;
    step(1);
    chk("R10", "oe at edge 1", rxout_oe, 1'b1);
    step(1);
    chk("R10", "oe at edge 2", rxout_oe, 1'b0);
    chk("R11", "ring monitor while tristated", ring_mon_en, 1'b1);
    pwr_down_n = 1'b0;
    step(5);
    rx_hiz = 1'b0;
    step(2);
    chk("R10", "oe restored in power-down", rxout_oe, 1'b1);
    chk("R11", "ring monitor at end", ring_mon_en, 1'b1);
  endtask

  initial begin
    t_reset();
    t_auto_wake();
    t_sleep_restart();
    t_wake_no_restart();
    t_status();
    t_shutdown();
    t_forced();
    t_rx_oe();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule